// File: doc/BRIEF.md
# Infrared Receive Byte Stream Parser

This block sits behind the receive FIFO of an infrared front end. The FIFO delivers bytes of two kinds, mixed in one stream. Some are command packets, made of an opcode, a subcommand and a payload whose length depends on the pair. The others are runs of sample bytes, each run announced by a header that carries its length. The parser walks this stream one byte at a time and drops the command packets. It turns every sample byte into a record made of a mark/space level and a duration in microseconds. A header that declares an empty run produces a one-cycle reset-event strobe, which tells the downstream decoder to restart.

Bytes arrive on a valid/ready interface. Records leave on a valid/ready interface with a single output register. The block takes no new byte while a record is still waiting to be accepted, so no sample is lost when the downstream side stalls. A header byte's top three bits and low five bits are read separately. A sample byte's top bit and low seven bits are read separately. The opcodes and subcommand codes are parameters.

Top module: `ir_stream_parser`

## Requirements
- R1: After reset, and after a reset applied in the middle of a packet, `out_valid_o` and `reset_evt_o` are 0 and `in_ready_o` is 1. The first byte accepted afterwards is read as a header.
- R2: A header byte is a command opcode if it equals 0x9F, or if its bits 7:5 differ from 3'b100. After a command opcode, the next byte is read as a subcommand. A command opcode produces no record and no event.
- R3: Any other header byte (bits 7:5 = 3'b100 and not 0x9F) declares that its bits 4:0 give the number of sample bytes that follow. After exactly that many sample bytes, the next byte is read as a header.
- R4: A sample header with bits 4:0 equal to 0 (the byte 0x80) raises `reset_evt_o` for exactly one cycle, in the cycle after the byte is accepted. The next byte is read as a header.
- R5: For each sample byte, the record appears in the cycle after the byte is accepted. `out_pulse_o` is bit 7 of the byte. `out_dur_us_o` is bits 6:0 of the byte multiplied by 50.
- R6: The payload length is set by the opcode and subcommand pair:
  - opcode 0x9F with subcommand 0x06, 0x0C or 0x15 carries 2 bytes;
  - opcode 0x9F with subcommand 0x01, 0x08 or 0x14 carries 1 byte;
  - opcode 0xFF with subcommand 0x0B carries 2 bytes;
  - opcode 0x00 with subcommand 0xFF carries 1 byte;
  - every other pair carries 0 bytes.
  Payload bytes produce no record and no event.
- R7: After the last payload byte, or directly after a subcommand whose payload is zero bytes, the next byte is read as a header. This keeps the parser aligned on the headers that follow.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, `in_ready_o` is 0 and the pending record stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte from the receive FIFO |
| in_ready_o | output | 1 | Parser accepts the byte this cycle |
| out_valid_o | output | 1 | Sample record valid |
| out_ready_i | input | 1 | Downstream accepts the record |
| out_pulse_o | output | 1 | Level: 1 is mark, 0 is space |
| out_dur_us_o | output | 16 | Duration in microseconds |
| reset_evt_o | output | 1 | One-cycle strobe for an empty sample header |

## Verification
Every one of the 256 values is applied as a header, followed by filler until the parser returns to the header state. This separates command opcodes, sample headers and the empty-run header, including 0x9F, which matches the sample pattern but is still a command. Every subcommand value is then tried under four opcodes (0x9F, 0x00, 0xFF and an unlisted one), each followed by a marker sample. A misjudged payload length shifts the alignment and shows up in that marker record.

Runs of 30 samples cover all 256 sample values, which tests the level bit and the duration arithmetic. Long random streams with random downstream stalls, a directed stall and a mid-packet reset cover the handshake and the restart behaviour.

// File: rtl/ir_parse_pkg.sv
package ir_parse_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_SUB  = 2'd1,
    ST_DATA = 2'd2,
    ST_IR   = 2'd3
  } parse_state_e;

  localparam logic [7:0] DEF_CMD_HDR  = 8'h9F;
  localparam logic [7:0] DEF_HW_HDR   = 8'hFF;
  localparam logic [7:0] DEF_NULL_CMD = 8'h00;
  localparam logic [7:0] DEF_REV_SUB  = 8'h0B;
  // packed lists of subcommands, three entries each
  localparam logic [23:0] DEF_SUB2_LIST = {8'h06, 8'h0C, 8'h15};
  localparam logic [23:0] DEF_SUB1_LIST = {8'h01, 8'h08, 8'h14};
endpackage

// File: rtl/ir_cmd_len.sv
module ir_cmd_len #(
  parameter logic [7:0]  CMD_HDR   = ir_parse_pkg::DEF_CMD_HDR,
  parameter logic [7:0]  HW_HDR    = ir_parse_pkg::DEF_HW_HDR,
  parameter logic [7:0]  NULL_CMD  = ir_parse_pkg::DEF_NULL_CMD,
  parameter logic [7:0]  REV_SUB   = ir_parse_pkg::DEF_REV_SUB,
  parameter int unsigned N_SUB2    = 3,
  parameter int unsigned N_SUB1    = 3,
  parameter logic [N_SUB2*8-1:0] SUB2_LIST = ir_parse_pkg::DEF_SUB2_LIST,
  parameter logic [N_SUB1*8-1:0] SUB1_LIST = ir_parse_pkg::DEF_SUB1_LIST
) (
  input  logic [7:0] cmd_i,
  input  logic [7:0] sub_i,
  output logic [1:0] len_o
);
  logic hit2, hit1;

  always_comb begin
    hit2 = 1'b0;
    hit1 = 1'b0;
    for (int i = 0; i < int'(N_SUB2); i++)
      if (sub_i == SUB2_LIST[i*8 +: 8]) hit2 = 1'b1;
    for (int i = 0; i < int'(N_SUB1); i++)
      if (sub_i == SUB1_LIST[i*8 +: 8]) hit1 = 1'b1;
  end

  always_comb begin
    len_o = 2'd0;
    if (cmd_i == CMD_HDR) begin
      if (hit2)      len_o = 2'd2;
      else if (hit1) len_o = 2'd1;
    end else if (cmd_i == HW_HDR) begin
      if (sub_i == REV_SUB) len_o = 2'd2;
    end else if (cmd_i == NULL_CMD) begin
      if (sub_i == HW_HDR) len_o = 2'd1;
    end
  end
endmodule

// File: rtl/ir_parse_fsm.sv
module ir_parse_fsm
  import ir_parse_pkg::*;
#(
  parameter int unsigned LEN_W     = 5,
  parameter logic [7:0]  CMD_HDR   = DEF_CMD_HDR,
  parameter logic [7:0]  HW_HDR    = DEF_HW_HDR,
  parameter logic [7:0]  NULL_CMD  = DEF_NULL_CMD,
  parameter logic [7:0]  REV_SUB   = DEF_REV_SUB,
  parameter logic [7-LEN_W:0] PULSE_PAT = 3'b100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output logic       sample_o,
  output logic       evt_o
);
  parse_state_e     state_q, state_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [1:0]       sub_len;

  ir_cmd_len #(
    .CMD_HDR (CMD_HDR),
    .HW_HDR  (HW_HDR),
    .NULL_CMD(NULL_CMD),
    .REV_SUB (REV_SUB)
  ) i_cmd_len (
    .cmd_i(cmd_q),
    .sub_i(byte_i),
    .len_o(sub_len)
  );

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    rem_d    = rem_q;
    sample_o = 1'b0;
    evt_o    = 1'b0;
    if (take_i) begin
      unique case (state_q)
        ST_HDR: begin
          cmd_d = byte_i;
          if (byte_i == CMD_HDR || byte_i[7:LEN_W] != PULSE_PAT) begin
            state_d = ST_SUB;
          end else begin
            rem_d = byte_i[LEN_W-1:0];
            if (rem_d != '0) state_d = ST_IR;
            else             evt_o   = 1'b1;
          end
        end
        ST_SUB: begin
          rem_d   = LEN_W'(sub_len);
          state_d = (sub_len == 2'd0) ? ST_HDR : ST_DATA;
        end
        ST_DATA: begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_d == '0) state_d = ST_HDR;
        end
        default: begin
          sample_o = 1'b1;
          rem_d    = rem_q - LEN_W'(1);
          if (rem_d == '0) state_d = ST_HDR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      cmd_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      rem_q   <= rem_d;
    end
  end

  AST_REM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA || state_q == ST_IR) |-> rem_q != '0); // R7
  AST_EVT_TO_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> state_q == ST_HDR); // R4
  AST_CMD_TO_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && state_q == ST_HDR && byte_i == CMD_HDR) |=> state_q == ST_SUB); // R2
endmodule

// File: rtl/ir_sample_out.sv
module ir_sample_out #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned DUR_W     = 16,
  parameter int unsigned SAMPLE_US = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  input  logic             evt_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_pulse_o,
  output logic [DUR_W-1:0] out_dur_o,
  output logic             evt_o
);
  localparam int unsigned MAX_DUR = ((1 << CNT_W) - 1) * SAMPLE_US;

  logic [DUR_W-1:0] dur_d;

  assign dur_d = DUR_W'(byte_i[CNT_W-1:0]) * DUR_W'(SAMPLE_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pulse_o <= 1'b0;
      out_dur_o   <= '0;
      evt_o       <= 1'b0;
    end else begin
      evt_o <= evt_i;
      if (load_i) begin
        out_valid_o <= 1'b1;
        out_pulse_o <= byte_i[7];
        out_dur_o   <= dur_d;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  AST_HOLD_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_dur_o) && $stable(out_pulse_o))); // R8
  AST_DUR_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(out_dur_o) <= MAX_DUR && (32'(out_dur_o) % SAMPLE_US) == 0)); // R5
endmodule

// File: rtl/ir_stream_parser.sv
module ir_stream_parser #(
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned DUR_W     = 16,
  parameter int unsigned SAMPLE_US = 50,
  parameter logic [7:0]  CMD_HDR   = ir_parse_pkg::DEF_CMD_HDR,
  parameter logic [7:0]  HW_HDR    = ir_parse_pkg::DEF_HW_HDR,
  parameter logic [7:0]  NULL_CMD  = ir_parse_pkg::DEF_NULL_CMD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_pulse_o,
  output logic [DUR_W-1:0] out_dur_us_o,
  output logic             reset_evt_o
);
  logic take, sample_load, evt;

  // a pending record blocks input unless it leaves this cycle
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  ir_parse_fsm #(
    .LEN_W   (LEN_W),
    .CMD_HDR (CMD_HDR),
    .HW_HDR  (HW_HDR),
    .NULL_CMD(NULL_CMD)
  ) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .byte_i  (in_data_i),
    .sample_o(sample_load),
    .evt_o   (evt)
  );

  ir_sample_out #(
    .CNT_W    (CNT_W),
    .DUR_W    (DUR_W),
    .SAMPLE_US(SAMPLE_US)
  ) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sample_load),
    .byte_i     (in_data_i),
    .evt_i      (evt),
    .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o),
    .out_pulse_o(out_pulse_o),
    .out_dur_o  (out_dur_us_o),
    .evt_o      (reset_evt_o)
  );

  AST_EVT_NO_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_evt_o |-> !$past(sample_load)); // R4
endmodule

// File: tb/test_ir_stream_parser.sv
module test_ir_stream_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_pulse;
  logic [15:0] out_dur;
  logic        reset_evt;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic bp_en = 1'b0;
  logic [31:0] rnd = 32'h1234_5678;

  // model state: 0 header, 1 subcommand, 2 payload, 3 samples
  int        m_st = 0;
  logic [7:0] m_cmd = 8'h00;
  int        m_rem = 0;
  logic [17:0] exp_q[$];   // {is_event, pulse, duration}

  logic        hold_chk = 1'b0;
  logic [16:0] hold_rec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_stream_parser i_ir_stream_parser (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_pulse_o (out_pulse),
    .out_dur_us_o(out_dur),
    .reset_evt_o (reset_evt)
  );

  function automatic logic [31:0] next_rnd();
    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 17);
    rnd = rnd ^ (rnd << 5);
    return rnd;
  endfunction

  function automatic int cmd_size(logic [7:0] c, logic [7:0] s);
    if (c == 8'h9F) begin
      if (s == 8'h06 || s == 8'h0C || s == 8'h15) return 2;
      if (s == 8'h01 || s == 8'h08 || s == 8'h14) return 1;
    end else if (c == 8'hFF) begin
      if (s == 8'h0B) return 2;
    end else if (c == 8'h00) begin
      if (s == 8'hFF) return 1;
    end
    return 0;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: begin
        m_cmd = b;
        if (b == 8'h9F || b[7:5] != 3'b100) m_st = 1;
        else if (b[4:0] == 5'd0) exp_q.push_back({1'b1, 1'b0, 16'd0});
        else begin m_rem = int'(b[4:0]); m_st = 3; end
      end
      1: begin
        m_rem = cmd_size(m_cmd, b);
        m_st = (m_rem == 0) ? 0 : 2;
      end
      2: begin
        m_rem--;
        if (m_rem == 0) m_st = 0;
      end
      default: begin
        exp_q.push_back({1'b0, b[7], 16'(b[6:0]) * 16'd50});
        m_rem--;
        if (m_rem == 0) m_st = 0;
      end
    endcase
  endtask

  task automatic check_rec(input logic [17:0] got);
    logic [17:0] e;
    n_vec++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R3 unexpected output: got %h expected none", got);
    end else begin
      e = exp_q.pop_front();
      if (e != got) begin
        n_bad++;
        if (e[17] || got[17])
          $display("FAIL R4 event/record mismatch: got %h expected %h", got, e);
        else
          $display("FAIL R5 record mismatch: got pulse %b dur %0d expected pulse %b dur %0d",
                   got[16], got[15:0], e[16], e[15:0]);
      end
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reset_evt) check_rec({1'b1, 1'b0, 16'd0});
      if (out_valid && out_ready) check_rec({1'b0, out_pulse, out_dur});
      if (hold_chk) begin
        n_vec++;
        if (!out_valid || {out_pulse, out_dur} != hold_rec) begin
          n_bad++;
          $display("FAIL R8 held record changed: got %b/%h expected 1/%h",
                   out_valid, {out_pulse, out_dur}, hold_rec);
        end
      end
      if (out_valid && !out_ready) begin
        n_vec++;
        if (in_ready) begin
          n_bad++;
          $display("FAIL R8 in_ready during stall: got 1 expected 0");
        end
        hold_chk = 1'b1;
        hold_rec = {out_pulse, out_dur};
      end else begin
        hold_chk = 1'b0;
      end
    end else begin
      hold_chk = 1'b0;
    end
  end

  // called #2 after a rising edge; returns #2 after the accepting edge
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    if (bp_en) out_ready = next_rnd()[3];
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #2;
      if (bp_en) out_ready = next_rnd()[3];
    end
    model_byte(b);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic fill_to_header();
    while (m_st != 0) send_byte(next_rnd()[7:0]);
  endtask

  task automatic chk_idle(input string tag);
    n_vec++;
    if (out_valid !== 1'b0 || reset_evt !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 %s: got valid %b evt %b ready %b expected 0 0 1",
               tag, out_valid, reset_evt, in_ready);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    m_st = 0; m_rem = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk_idle("in reset");
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk); chk_idle("after reset");
    @(posedge clk); #2;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 missing outputs: got %0d left expected 0", exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();   // R1

    // R5, R3: every sample value in runs of 30 (0x9E)
    for (int blk = 0; blk < 9; blk++) begin
      send_byte(8'h9E);
      for (int i = 0; i < 30; i++) send_byte(8'((blk * 30 + i) % 256));
    end
    drain();

    // R2, R3, R4: every header value, then filler back to header
    for (int h = 0; h < 256; h++) begin
      send_byte(8'(h));
      fill_to_header();
      send_byte(8'h81);
      send_byte(8'(h) | 8'h80);
    end
    drain();

    // R6, R7: every subcommand under four opcodes, then a marker sample
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 256; s++) begin
        send_byte((k == 0) ? 8'h9F : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h42);
        send_byte(8'(s));
        while (m_st != 0) send_byte(8'h81);   // payload that looks like a header
        send_byte(8'h81);
        send_byte(8'(s) ^ 8'h5A);
      end
    end
    drain();

    // R8: directed stall with a byte waiting
    out_ready = 1'b0;
    send_byte(8'h82);
    send_byte(8'hC5);
    fork
      send_byte(8'h07);
      begin repeat (5) @(posedge clk); #3; out_ready = 1'b1; end
    join
    drain();

    // R8, R3: random stream with random stalls
    bp_en = 1'b1;
    for (int i = 0; i < 4000; i++) send_byte(next_rnd()[7:0]);
    bp_en = 1'b0;
    fill_to_header();
    drain();

    // R1: reset in the middle of a sample run
    send_byte(8'h85);
    send_byte(8'h10);
    drain();
    do_reset();
    send_byte(8'h81);
    send_byte(8'h22);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule